// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block turns internal read and write requests into strobe sequences on an external 16-bit memory bus. It drives an active-low chip select together with an active-low read strobe or an active-low write strobe. Every bus access lasts one base cycle plus a programmable number of standard wait states. Once those standard cycles have run out, an active-low wait input from the external device can hold the access open for as long as it stays low. Chip select, the active strobe and the read-data sampling point all move with the true end of the stretched access.

An internal 32-bit request goes out as two 16-bit bus accesses, low half first, with one idle bus cycle between them. The read halves are joined into one word. For a write, the word is split across the two accesses. Byte and halfword requests use a single access.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a held request waits without loss, and the request fields only have to be stable while `req_valid` is high. The response side is a one-cycle `rsp_ack` pulse, and `rsp_rdata` is valid in that cycle. The response cannot be back-pressured, so the requester must be ready to take it.

Top module: `ebus_wait_ctrl`

## Requirements
- R1: After reset, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are high, `rsp_ack` is low and `req_ready` is high.
- R2: A read access holds `bus_cs_n` and `bus_rd_n` low together for exactly W+1 cycles when the wait input stays high, where W is the programmed wait-state count. `bus_wr_n` stays high throughout, and both strobes rise in the same cycle as chip select.
- R3: A write access holds `bus_cs_n` and `bus_wr_n` low together and `bus_rd_n` high. `bus_wdata` carries the request's low 16 bits and holds steady for the whole access.
- R4: The wait input is sampled on the rising edge. Each consecutive low sample, starting with the last standard cycle (strobe cycle index W, counting from 0), adds one cycle to chip select and to the active strobe. The access ends at the first high sample at or after index W.
- R5: A low wait input during strobe cycles with index below W has no effect on the access length.
- R6: Read data for each bus access is captured at the clock edge that ends that access, including any extension.
- R7: A word request (`req_size`=2) makes two accesses. The first uses `req_addr` and `req_wdata[15:0]`. The second uses `req_addr`+2 and `req_wdata[31:16]`. Chip select is high for exactly one cycle between them, and each access is stretched independently.
- R8: For a word read, `rsp_rdata` is {second access data, first access data}.
- R9: `rsp_ack` is high for exactly one cycle: the first cycle after the last access ends. `req_ready` is low from the cycle after acceptance until that cycle.
- R10: Byte (`req_size`=0) and halfword (`req_size`=1) requests make one access. A byte read returns the lane chosen by `req_addr[0]` (0 selects bits 7:0, 1 selects bits 15:8), zero-extended. A halfword read is zero-extended. A byte write drives `req_wdata[7:0]` on both bus lanes.
- R11: The wait-state count is captured when a request is accepted, so later changes do not affect the access in progress. A count of 0 gives a one-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait_states | input | 3 | Standard wait states per access (0 to 7) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid while `rsp_ack` is high |
| bus_addr | output | 24 | External address |
| bus_wdata | output | 16 | External write data |
| bus_rdata | input | 16 | External read data |
| bus_wait_n | input | 1 | Active-low wait from the device |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |

## Verification
On every cycle the assertions check the following:
- The wait-state counter stays within its programmed limit.
- A strobe never ends before the standard count is reached, and never ends while wait is sampled low.
- Exactly one strobe is active whenever chip select is low, and none while it is high.
- Write data is stable during an access.
- The second half of a word access carries the address plus two.
- The acknowledge lasts a single cycle.

Only the bench scenarios can show the exact stretched lengths for given wait patterns, including wait pulses that arrive before the standard count ends. The same applies to the choice of which sampled value becomes read data, to how a word is assembled, to byte-lane selection and replication, and to capturing the configuration at acceptance.

// File: rtl/ebus_pkg.sv
`timescale 1ns/1ps
package ebus_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STRB = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ebus_wait_timer.sv
`timescale 1ns/1ps
module ebus_wait_timer #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [WS_W-1:0] ws_lim,
  input  logic            wait_n,
  output logic            half_end
);
  logic [WS_W-1:0] cnt;
  logic            std_done;

  assign std_done = (cnt == ws_lim);
  assign half_end = active && std_done && wait_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!active) begin
      cnt <= '0;
    end else if (!std_done) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ws_lim);

  // R5
  std_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !std_done) |=> active);

  // R4
  wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && std_done && !wait_n) |=> active);
endmodule

// File: rtl/ebus_seq.sv
`timescale 1ns/1ps
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int AW   = 24,
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      req_size,
  input  logic [AW-1:0]   req_addr,
  input  logic [WS_W-1:0] cfg_ws,
  input  logic            half_end,
  output logic            req_ready,
  output logic            active,
  output logic [WS_W-1:0] ws_lim,
  output logic            hi_half,
  output logic            ack,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_cs_n,
  output logic            bus_rd_n,
  output logic            bus_wr_n
);
  localparam logic [AW-1:0] HALF_STEP = AW'(2);

  seq_state_e  state;
  xfer_size_e  size_q;
  logic        wr_q;
  logic [AW-1:0] addr_q;

  assign req_ready = (state == ST_IDLE);
  assign active    = (state == ST_STRB);
  assign bus_cs_n  = !active;
  assign bus_rd_n  = !(active && !wr_q);
  assign bus_wr_n  = !(active && wr_q);
  assign bus_addr  = hi_half ? addr_q + HALF_STEP : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      size_q  <= SZ_BYTE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      ws_lim  <= '0;
      hi_half <= 1'b0;
      ack     <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            size_q  <= xfer_size_e'(req_size);
            wr_q    <= req_write;
            addr_q  <= req_addr;
            ws_lim  <= cfg_ws;
            hi_half <= 1'b0;
            state   <= ST_STRB;
          end
        end
        ST_STRB: begin
          if (half_end) begin
            if (size_q == SZ_WORD && !hi_half) begin
              hi_half <= 1'b1;
              state   <= ST_GAP;
            end else begin
              ack   <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        ST_GAP:  state <= ST_STRB;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> (bus_rd_n != bus_wr_n));

  // R2
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> (bus_rd_n && bus_wr_n));

  // R7
  half_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_cs_n) && hi_half) |-> (bus_addr == $past(bus_addr, 2) + HALF_STEP));

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R9
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (bus_cs_n && $past(!bus_cs_n)));
endmodule

// File: rtl/ebus_datapath.sv
`timescale 1ns/1ps
module ebus_datapath
  import ebus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [2*BUS_W-1:0] req_wdata,
  input  logic [1:0]         req_size,
  input  logic               req_lsb,
  input  logic               hi_half,
  input  logic               half_end,
  input  logic               cs_n,
  input  logic [BUS_W-1:0]   bus_rdata,
  output logic [BUS_W-1:0]   bus_wdata,
  output logic [2*BUS_W-1:0] rd_data
);
  localparam int LANE_W = BUS_W / 2;

  logic [2*BUS_W-1:0] wd_q;
  xfer_size_e         size_q;
  logic               lsb_q;
  logic [BUS_W-1:0]   lo_q;
  logic               final_end;
  logic [2*BUS_W-1:0] rd_next;

  assign final_end = half_end && (size_q != SZ_WORD || hi_half);

  always_comb begin
    if (hi_half)
      bus_wdata = wd_q[2*BUS_W-1:BUS_W];
    else if (size_q == SZ_BYTE)
      bus_wdata = {wd_q[LANE_W-1:0], wd_q[LANE_W-1:0]};
    else
      bus_wdata = wd_q[BUS_W-1:0];
  end

  always_comb begin
    case (size_q)
      SZ_WORD: rd_next = {bus_rdata, lo_q};
      SZ_BYTE: rd_next = lsb_q ? {{(2*BUS_W-LANE_W){1'b0}}, bus_rdata[BUS_W-1:LANE_W]}
                               : {{(2*BUS_W-LANE_W){1'b0}}, bus_rdata[LANE_W-1:0]};
      default: rd_next = {{BUS_W{1'b0}}, bus_rdata};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q    <= '0;
      size_q  <= SZ_BYTE;
      lsb_q   <= 1'b0;
      lo_q    <= '0;
      rd_data <= '0;
    end else begin
      if (accept) begin
        wd_q   <= req_wdata;
        size_q <= xfer_size_e'(req_size);
        lsb_q  <= req_lsb;
      end
      if (half_end && !hi_half)
        lo_q <= bus_rdata;
      if (final_end)
        rd_data <= rd_next;
    end
  end

  // R3
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(bus_wdata));
endmodule

// File: rtl/ebus_wait_ctrl.sv
`timescale 1ns/1ps
module ebus_wait_ctrl #(
  parameter int AW    = 24,
  parameter int WS_W  = 3,
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WS_W-1:0]    cfg_wait_states,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic [AW-1:0]      req_addr,
  input  logic [2*BUS_W-1:0] req_wdata,
  output logic               rsp_ack,
  output logic [2*BUS_W-1:0] rsp_rdata,
  output logic [AW-1:0]      bus_addr,
  output logic [BUS_W-1:0]   bus_wdata,
  input  logic [BUS_W-1:0]   bus_rdata,
  input  logic               bus_wait_n,
  output logic               bus_cs_n,
  output logic               bus_rd_n,
  output logic               bus_wr_n
);
  logic            active;
  logic [WS_W-1:0] ws_lim;
  logic            half_end;
  logic            hi_half;
  logic            accept;

  assign accept = req_valid && req_ready;

  ebus_seq #(.AW(AW), .WS_W(WS_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .cfg_ws(cfg_wait_states), .half_end(half_end),
    .req_ready(req_ready), .active(active), .ws_lim(ws_lim),
    .hi_half(hi_half), .ack(rsp_ack), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  ebus_wait_timer #(.WS_W(WS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(active), .ws_lim(ws_lim),
    .wait_n(bus_wait_n), .half_end(half_end)
  );

  ebus_datapath #(.BUS_W(BUS_W)) u_data (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_wdata(req_wdata),
    .req_size(req_size), .req_lsb(req_addr[0]), .hi_half(hi_half),
    .half_end(half_end), .cs_n(bus_cs_n), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .rd_data(rsp_rdata)
  );
endmodule

// File: tb/ebus_wait_ctrl_tb.sv
`timescale 1ns/1ps
module ebus_wait_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_wait_states = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ack;
  logic [31:0] rsp_rdata;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_wait_n = 1'b1;
  logic        bus_cs_n, bus_rd_n, bus_wr_n;

  int total = 0;
  int bad = 0;

  // monitor state
  int          cyc = 0;
  int          seg_n = 0;
  int          idx = 0;
  bit          in_seg = 0;
  int          seg_len [2];
  logic [23:0] seg_addr [2];
  logic [15:0] seg_wd [2];
  int          gap = 0, mm = 0, ack_cnt = 0, ack_cyc = 0, rise_cyc = 0;
  logic [31:0] ack_data = '0;
  logic [15:0] m_mask [2];
  logic [15:0] m_val [2];
  bit          t_write = 0;

  ebus_wait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wait_states(cfg_wait_states),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait_n(bus_wait_n),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus-side model: drives wait and read data, records each strobe segment
  initial begin
    m_mask[0] = '0; m_mask[1] = '0; m_val[0] = '0; m_val[1] = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (req_valid) begin
        seg_n = 0; in_seg = 0; gap = 0; mm = 0; ack_cnt = 0; idx = 0;
      end
      if (!bus_cs_n) begin
        if (!in_seg) begin
          in_seg = 1; idx = 0;
          if (seg_n < 2) begin seg_addr[seg_n] = bus_addr; seg_wd[seg_n] = bus_wdata; end
        end else idx++;
        if (t_write ? (bus_wr_n || !bus_rd_n) : (bus_rd_n || !bus_wr_n)) mm++;
        if (seg_n < 2 && idx < 16) begin
          bus_wait_n = !m_mask[seg_n][idx];
          bus_rdata  = m_val[seg_n] ^ 16'(idx);
        end else begin
          bus_wait_n = 1'b1;
        end
      end else begin
        if (!bus_rd_n || !bus_wr_n) mm++;
        bus_wait_n = 1'b1;
        bus_rdata  = 16'hBEEF;
        if (in_seg) begin
          if (seg_n < 2) seg_len[seg_n] = idx + 1;
          in_seg = 0; seg_n++; rise_cyc = cyc;
        end
        if (seg_n == 1) gap++;
      end
      if (rsp_ack) begin ack_cnt++; ack_cyc = cyc; ack_data = rsp_rdata; end
    end
  end

  function automatic int ext_cycles(int ws, logic [15:0] m);
    int e = 0;
    for (int k = ws; k < 16; k++) begin
      if (!m[k]) break;
      e++;
    end
    return e;
  endfunction

  task automatic run(string nm, bit wr, logic [1:0] sz, logic [23:0] ad, logic [31:0] wd,
                     int ws, int ws_after, logic [15:0] mk0, logic [15:0] mk1,
                     logic [15:0] v0, logic [15:0] v1);
    int len0, len1, nseg;
    logic [15:0] cap0, cap1;
    logic [31:0] exp_rd;
    len0 = ws + 1 + ext_cycles(ws, mk0);
    len1 = ws + 1 + ext_cycles(ws, mk1);
    nseg = (sz == 2'd2) ? 2 : 1;
    cap0 = v0 ^ 16'(len0 - 1);
    cap1 = v1 ^ 16'(len1 - 1);
    @(negedge clk); #1;
    chk("R9", {nm, " ready idle"}, 32'(req_ready), 32'd1);
    cfg_wait_states = 3'(ws);
    m_mask[0] = mk0; m_mask[1] = mk1; m_val[0] = v0; m_val[1] = v1;
    t_write = wr; req_write = wr; req_size = sz; req_addr = ad; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    cfg_wait_states = 3'(ws_after);
    chk("R9", {nm, " ready busy"}, 32'(req_ready), 32'd0);
    for (int i = 0; i < 200 && ack_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R7", {nm, " access count"}, 32'(seg_n), 32'(nseg));
    chk("R4", {nm, " first length"}, 32'(seg_len[0]), 32'(len0));
    chk("R2", {nm, " strobe type"}, 32'(mm), 32'd0);
    chk("R7", {nm, " first addr"}, 32'(seg_addr[0]), 32'(ad));
    if (wr) begin
      chk("R3", {nm, " first wdata"}, 32'(seg_wd[0]),
          (sz == 2'd0) ? 32'({wd[7:0], wd[7:0]}) : 32'(wd[15:0]));
    end
    if (nseg == 2) begin
      chk("R4", {nm, " second length"}, 32'(seg_len[1]), 32'(len1));
      chk("R7", {nm, " gap"}, 32'(gap), 32'd1);
      chk("R7", {nm, " second addr"}, 32'(seg_addr[1]), 32'(ad + 24'd2));
      if (wr) chk("R7", {nm, " second wdata"}, 32'(seg_wd[1]), 32'(wd[31:16]));
    end
    chk("R9", {nm, " ack count"}, 32'(ack_cnt), 32'd1);
    chk("R9", {nm, " ack timing"}, 32'(ack_cyc), 32'(rise_cyc));
    if (!wr) begin
      if (sz == 2'd2)      exp_rd = {cap1, cap0};
      else if (sz == 2'd1) exp_rd = {16'h0, cap0};
      else                 exp_rd = ad[0] ? {24'h0, cap0[15:8]} : {24'h0, cap0[7:0]};
      chk("R6", {nm, " read data"}, ack_data, exp_rd);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "cs", 32'(bus_cs_n), 32'd1);
    chk("R1", "rd", 32'(bus_rd_n), 32'd1);
    chk("R1", "wr", 32'(bus_wr_n), 32'd1);
    chk("R1", "ack", 32'(rsp_ack), 32'd0);
    chk("R1", "ready", 32'(req_ready), 32'd1);
  endtask

  // R2: plain halfword read, one wait state
  task automatic t_half_read();  run("R2 half read", 0, 2'd1, 24'h000100, 32'h0, 1, 1, 16'h0, 16'h0, 16'h1230, 16'h0); endtask
  // R3: halfword write, three wait states
  task automatic t_half_write(); run("R3 half write", 1, 2'd1, 24'h000200, 32'hAAAA_5A5A, 3, 3, 16'h0, 16'h0, 16'h0, 16'h0); endtask
  // R4 R6: wait high in first cycle, low in later cycles
  task automatic t_wait_late();  run("R4 wait late", 0, 2'd1, 24'h000300, 32'h0, 1, 1, 16'b0110, 16'h0, 16'h4C00, 16'h0); endtask
  // R5: wait low only before the standard count ends
  task automatic t_wait_early(); run("R5 wait early", 0, 2'd1, 24'h000400, 32'h0, 2, 2, 16'b0011, 16'h0, 16'h7700, 16'h0); endtask
  // R7 R8: word read, each half stretched differently
  task automatic t_word_read();  run("R8 word read", 0, 2'd2, 24'h001000, 32'h0, 1, 1, 16'b0010, 16'b0110, 16'h1100, 16'h2200); endtask
  // R7 R11: word write, zero wait states, second half stretched
  task automatic t_word_write(); run("R7 word write", 1, 2'd2, 24'h002000, 32'hCAFE_F00D, 0, 0, 16'h0, 16'b0001, 16'h0, 16'h0); endtask
  // R10: byte read on odd address, byte write lane replication
  task automatic t_bytes();
    run("R10 byte read", 0, 2'd0, 24'h003001, 32'h0, 2, 2, 16'h0, 16'h0, 16'hAB00, 16'h0);
    run("R10 byte write", 1, 2'd0, 24'h003002, 32'h0000_00C3, 1, 1, 16'h0, 16'h0, 16'h0, 16'h0);
  endtask
  // R11: zero wait states, then config changed mid access
  task automatic t_cfg_latch();
    run("R11 zero ws", 0, 2'd1, 24'h004000, 32'h0, 0, 0, 16'h0, 16'h0, 16'h0F00, 16'h0);
    run("R11 cfg latch", 0, 2'd1, 24'h004010, 32'h0, 2, 7, 16'h0, 16'h0, 16'h3300, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_half_read();
    t_half_write();
    t_wait_late();
    t_wait_early();
    t_word_read();
    t_word_write();
    t_bytes();
    t_cfg_latch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule